// File: doc/BRIEF.md
# Narrow-Bus Cache Line Fill Engine

This block refills one cache line from a memory port that is narrower than the cache word. A start request carries the line's address, counted in 32-bit words. The engine then walks the line one halfword at a time on a 16-bit read-master port. The memory address on that port counts halfwords and is 24 bits wide. Every beat is its own single read transaction: the engine drives the address and raises read, then holds both until the cycle in which the slave's wait-request is low. In that cycle it captures the read data.

Between two beats the read strobe drops for one cycle while the next address is set up. The engine joins each pair of captured halfwords into one 32-bit word and writes it, with the word's position in the line, through a single-cycle write port into the cache data array. A 64-byte line takes 32 beats and 16 word writes. After the last word is written, a one-cycle done pulse follows. Start requests that arrive while a fill is running have no effect.

Top module: `line_fill_engine`

## Requirements
- R1: While reset is high and in the first cycle after it, read, write enable, done and busy are all low.
- R2: A start sampled while idle makes read high in the next cycle, with the memory address equal to the line word address shifted left by one (line address times two).
- R3: While read is high and wait-request is high, read stays high and the address does not change.
- R4: A beat completes in a cycle where read is high and wait-request is low. Read is then low for exactly one cycle, and when it rises again the address is the previous beat's address plus one.
- R5: One fill is exactly 32 completed beats on consecutive halfword addresses.
- R6: Each written word holds the halfword from the lower address in bits [15:0] and the halfword from the next address in bits [31:16].
- R7: A write happens in the cycle after each odd-numbered beat (1, 3, ..., 31, counting from 0) completes. Its index is that beat's number divided by two, so the indices 0 to 15 are each written once per fill.
- R8: Done is high for exactly one cycle, in the cycle after the 16th write. Busy is high from the cycle after an accepted start up to and including the 16th write cycle, and low while done is high.
- R9: A start raised while busy is high changes neither the address sequence nor the written data of the running fill.
- R10: Address arithmetic is 24 bits wide. A line at the top of the word space (word address 0x7FFFF0) reads halfwords 0xFFFFE0 to 0xFFFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Fill request, sampled while idle |
| line_addr_i | input | 23 | Line start address, in 32-bit words |
| mem_addr_o | output | 24 | Halfword address to memory |
| mem_read_o | output | 1 | Read strobe to memory |
| mem_waitreq_i | input | 1 | Memory stall; beat completes when low with read high |
| mem_rdata_i | input | 16 | Memory read data, valid on completing beat |
| wr_en_o | output | 1 | Cache word write strobe |
| wr_idx_o | output | 4 | Word index within the line |
| wr_data_o | output | 32 | Packed cache word |
| busy_o | output | 1 | Fill in progress |
| done_o | output | 1 | One-cycle fill-complete pulse |

## Verification
Two situations are hard to reach from the ports. One is a start that arrives in the middle of a fill while the memory is stalling. The other is a restart that is accepted in the very cycle done is high. The bench holds start high through whole fills and pulses it during long wait-request stalls, so both happen. A pseudo-random stall generator, a zero-wait mode and a mostly-stalled mode vary where beats complete relative to each other. One fill at the top of the address space exercises the 24-bit address carry.

// File: rtl/line_fill_pkg.sv
package line_fill_pkg;
  typedef enum logic [1:0] {
    FS_IDLE  = 2'd0,
    FS_ISSUE = 2'd1,
    FS_GAP   = 2'd2,
    FS_LAST  = 2'd3
  } fill_state_e;
endpackage

// File: rtl/fill_beat_sequencer.sv
module fill_beat_sequencer
  import line_fill_pkg::*;
#(
  parameter int MEM_AW  = 24,
  parameter int LANE_W  = 1,
  parameter int BEATS   = 32,
  parameter int LINE_AW = MEM_AW - LANE_W,
  parameter int BEAT_W  = $clog2(BEATS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [LINE_AW-1:0] line_addr_i,
  input  logic               waitreq_i,
  output logic [MEM_AW-1:0]  mem_addr_o,
  output logic               mem_read_o,
  output logic               beat_ok_o,
  output logic [BEAT_W-1:0]  beat_idx_o,
  output logic               busy_o,
  output logic               done_o
);
  fill_state_e state_q;
  logic [MEM_AW-1:0] addr_q;
  logic [BEAT_W-1:0] beat_q;
  logic read_q, busy_q, done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= FS_IDLE;
      addr_q  <= '0;
      beat_q  <= '0;
      read_q  <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        FS_IDLE: begin
          if (start_i) begin
            addr_q  <= {line_addr_i, {LANE_W{1'b0}}};
            beat_q  <= '0;
            read_q  <= 1'b1;
            busy_q  <= 1'b1;
            state_q <= FS_ISSUE;
          end
        end
        FS_ISSUE: begin
          if (!waitreq_i) begin
            read_q <= 1'b0;
            if (beat_q == BEAT_W'(BEATS - 1)) begin
              state_q <= FS_LAST;
            end else begin
              addr_q  <= addr_q + MEM_AW'(1);
              beat_q  <= beat_q + BEAT_W'(1);
              state_q <= FS_GAP;
            end
          end
        end
        FS_GAP: begin
          read_q  <= 1'b1;
          state_q <= FS_ISSUE;
        end
        default: begin
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
          state_q <= FS_IDLE;
        end
      endcase
    end
  end

  assign mem_addr_o = addr_q;
  assign mem_read_o = read_q;
  assign beat_ok_o  = read_q & ~waitreq_i;
  assign beat_idx_o = beat_q;
  assign busy_o     = busy_q;
  assign done_o     = done_q;
endmodule

// File: rtl/halfword_packer.sv
module halfword_packer #(
  parameter int MEM_DW   = 16,
  parameter int CACHE_DW = 32,
  parameter int BEAT_W   = 5,
  parameter int LANES    = CACHE_DW / MEM_DW,
  parameter int LANE_W   = $clog2(LANES),
  parameter int IDX_W    = BEAT_W - LANE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                beat_ok_i,
  input  logic [BEAT_W-1:0]   beat_idx_i,
  input  logic [MEM_DW-1:0]   rdata_i,
  output logic                wr_en_o,
  output logic [IDX_W-1:0]    wr_idx_o,
  output logic [CACHE_DW-1:0] wr_data_o
);
  logic [LANE_W-1:0]   lane;
  logic [CACHE_DW-1:0] word_next;
  logic [MEM_DW-1:0]   part_q [LANES-1];
  logic                word_full;

  assign lane      = beat_idx_i[LANE_W-1:0];
  assign word_full = beat_ok_i && (lane == LANE_W'(LANES - 1));

  for (genvar l = 0; l < LANES - 1; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        part_q[l] <= '0;
      end else if (beat_ok_i && (lane == LANE_W'(l))) begin
        part_q[l] <= rdata_i;
      end
    end
    assign word_next[l*MEM_DW +: MEM_DW] = part_q[l];
  end
  assign word_next[CACHE_DW-1 -: MEM_DW] = rdata_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en_o   <= 1'b0;
      wr_idx_o  <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= word_full;
      if (word_full) begin
        wr_idx_o  <= beat_idx_i[BEAT_W-1:LANE_W];
        wr_data_o <= word_next;
      end
    end
  end
endmodule

// File: rtl/line_fill_engine.sv
module line_fill_engine #(
  parameter int MEM_AW     = 24,
  parameter int MEM_DW     = 16,
  parameter int CACHE_DW   = 32,
  parameter int LINE_BYTES = 64,
  parameter int LANES      = CACHE_DW / MEM_DW,
  parameter int LANE_W     = $clog2(LANES),
  parameter int LINE_AW    = MEM_AW - LANE_W,
  parameter int BEATS      = LINE_BYTES / (MEM_DW / 8),
  parameter int BEAT_W     = $clog2(BEATS),
  parameter int IDX_W      = BEAT_W - LANE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic [LINE_AW-1:0]  line_addr_i,
  output logic [MEM_AW-1:0]   mem_addr_o,
  output logic                mem_read_o,
  input  logic                mem_waitreq_i,
  input  logic [MEM_DW-1:0]   mem_rdata_i,
  output logic                wr_en_o,
  output logic [IDX_W-1:0]    wr_idx_o,
  output logic [CACHE_DW-1:0] wr_data_o,
  output logic                busy_o,
  output logic                done_o
);
  logic              beat_ok;
  logic [BEAT_W-1:0] beat_idx;

  fill_beat_sequencer #(
    .MEM_AW (MEM_AW),
    .LANE_W (LANE_W),
    .BEATS  (BEATS),
    .LINE_AW(LINE_AW),
    .BEAT_W (BEAT_W)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .line_addr_i(line_addr_i),
    .waitreq_i  (mem_waitreq_i),
    .mem_addr_o (mem_addr_o),
    .mem_read_o (mem_read_o),
    .beat_ok_o  (beat_ok),
    .beat_idx_o (beat_idx),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  halfword_packer #(
    .MEM_DW  (MEM_DW),
    .CACHE_DW(CACHE_DW),
    .BEAT_W  (BEAT_W),
    .LANES   (LANES),
    .LANE_W  (LANE_W),
    .IDX_W   (IDX_W)
  ) u_pack (
    .clk       (clk),
    .rst       (rst),
    .beat_ok_i (beat_ok),
    .beat_idx_i(beat_idx),
    .rdata_i   (mem_rdata_i),
    .wr_en_o   (wr_en_o),
    .wr_idx_o  (wr_idx_o),
    .wr_data_o (wr_data_o)
  );
endmodule

// File: rtl/line_fill_engine_chk.sv
module line_fill_engine_chk #(
  parameter int MEM_AW  = 24,
  parameter int LINE_AW = 23,
  parameter int LANE_W  = 1,
  parameter int BEATS   = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               start_i,
  input logic [LINE_AW-1:0] line_addr_i,
  input logic [MEM_AW-1:0]  mem_addr_o,
  input logic               mem_read_o,
  input logic               mem_waitreq_i,
  input logic               wr_en_o,
  input logic               busy_o,
  input logic               done_o
);
  logic [7:0] beat_cnt;

  always_ff @(posedge clk) begin
    if (rst) beat_cnt <= '0;
    else if (start_i && !busy_o) beat_cnt <= '0;
    else if (mem_read_o && !mem_waitreq_i) beat_cnt <= beat_cnt + 8'd1;
  end

  a_r2_start_addr: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && !done_o) |=> (mem_read_o && mem_addr_o == {$past(line_addr_i), {LANE_W{1'b0}}}));

  a_r3_hold_stall: assert property (@(posedge clk) disable iff (rst)
    (mem_read_o && mem_waitreq_i) |=> (mem_read_o && $stable(mem_addr_o)));

  a_r4_gap_after_beat: assert property (@(posedge clk) disable iff (rst)
    (mem_read_o && !mem_waitreq_i) |=> !mem_read_o);

  a_r4_next_addr: assert property (@(posedge clk) disable iff (rst)
    (!mem_read_o && busy_o && $past(mem_read_o)) |=> (mem_read_o || wr_en_o || done_o || !busy_o));

  a_r5_beat_total: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (beat_cnt == 8'(BEATS)));

  a_r7_write_follows_beat: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> $past(mem_read_o && !mem_waitreq_i));

  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r8_done_after_write: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ($past(wr_en_o) && !busy_o));
endmodule

bind line_fill_engine line_fill_engine_chk #(
  .MEM_AW (MEM_AW),
  .LINE_AW(LINE_AW),
  .LANE_W (LANE_W),
  .BEATS  (BEATS)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .start_i      (start_i),
  .line_addr_i  (line_addr_i),
  .mem_addr_o   (mem_addr_o),
  .mem_read_o   (mem_read_o),
  .mem_waitreq_i(mem_waitreq_i),
  .wr_en_o      (wr_en_o),
  .busy_o       (busy_o),
  .done_o       (done_o)
);

// File: tb/line_fill_engine_test.sv
module line_fill_engine_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [22:0] line_addr_i = '0;
  logic [23:0] mem_addr_o;
  logic        mem_read_o;
  logic        mem_waitreq_i = 1'b0;
  logic [15:0] mem_rdata_i;
  logic        wr_en_o;
  logic [3:0]  wr_idx_o;
  logic [31:0] wr_data_o;
  logic        busy_o;
  logic        done_o;

  int checks = 0;
  int failures = 0;
  int wait_mode = 0;
  logic [7:0] lfsr = 8'h5B;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] mem_word(input logic [23:0] a);
    return a[15:0] ^ {a[23:16], a[23:16]} ^ 16'h5A3C;
  endfunction

  assign mem_rdata_i = mem_word(mem_addr_o);

  line_fill_engine uut (
    .clk(clk), .rst(rst), .start_i(start_i), .line_addr_i(line_addr_i),
    .mem_addr_o(mem_addr_o), .mem_read_o(mem_read_o),
    .mem_waitreq_i(mem_waitreq_i), .mem_rdata_i(mem_rdata_i),
    .wr_en_o(wr_en_o), .wr_idx_o(wr_idx_o), .wr_data_o(wr_data_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  // stall generator, driven just after each rising edge
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    case (wait_mode)
      0: mem_waitreq_i = 1'b0;
      1: mem_waitreq_i = lfsr[0];
      default: mem_waitreq_i = (lfsr[2:0] != 3'b000);
    endcase
  end

  // behavioural reference model
  int          m_phase = 0;
  int          m_beat = 0;
  logic [23:0] m_addr = '0;
  logic [15:0] m_low = '0;
  logic        e_read = 0, e_wren = 0, e_done = 0, e_busy = 0;
  logic [3:0]  e_idx = '0;
  logic [31:0] e_data = '0;

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_beat = 0; e_wren = 0; e_done = 0;
    end else begin
      e_wren = 0;
      e_done = 0;
      case (m_phase)
        0: if (start_i) begin
          m_addr = {line_addr_i, 1'b0};
          m_beat = 0;
          m_phase = 1;
        end
        1: if (!mem_waitreq_i) begin
          if (m_beat % 2 == 1) begin
            e_wren = 1;
            e_data = {mem_word(m_addr), m_low};
            e_idx = 4'(m_beat / 2);
          end else begin
            m_low = mem_word(m_addr);
          end
          if (m_beat == 31) m_phase = 3;
          else begin
            m_phase = 2;
            m_addr = m_addr + 24'd1;
            m_beat = m_beat + 1;
          end
        end
        2: m_phase = 1;
        default: begin
          e_done = 1;
          m_phase = 0;
        end
      endcase
    end
    e_read = (m_phase == 1);
    e_busy = (m_phase != 0);
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-fill tallies, taken from the ports
  int beats_seen = 0, writes_seen = 0;
  logic [15:0] idx_mask = '0;
  bit compare_on = 0;

  always @(negedge clk) begin
    if (compare_on && !rst) begin
      chk(mem_read_o == e_read, "R3/R4 read strobe", 32'(mem_read_o), 32'(e_read));
      if (e_read) chk(mem_addr_o == m_addr, "R2/R4/R10 address", 32'(mem_addr_o), 32'(m_addr));
      chk(wr_en_o == e_wren, "R7 write enable", 32'(wr_en_o), 32'(e_wren));
      if (e_wren) begin
        chk(wr_idx_o == e_idx, "R7 write index", 32'(wr_idx_o), 32'(e_idx));
        chk(wr_data_o == e_data, "R6/R9 packed word", wr_data_o, e_data);
      end
      chk(done_o == e_done, "R8 done pulse", 32'(done_o), 32'(e_done));
      chk(busy_o == e_busy, "R8/R9 busy", 32'(busy_o), 32'(e_busy));
      if (mem_read_o && !mem_waitreq_i) beats_seen++;
      if (wr_en_o) begin
        writes_seen++;
        idx_mask[wr_idx_o] = 1'b1;
      end
      if (done_o) begin
        chk(beats_seen == 32, "R5 beats per fill", 32'(beats_seen), 32);
        chk(writes_seen == 16, "R7 writes per fill", 32'(writes_seen), 16);
        chk(idx_mask == 16'hFFFF, "R7 index coverage", 32'(idx_mask), 32'hFFFF);
        beats_seen = 0; writes_seen = 0; idx_mask = '0;
      end
    end
  end

  task automatic drive_start(input logic [22:0] a);
    @(posedge clk); #2;
    line_addr_i = a;
    start_i = 1'b1;
    @(posedge clk); #2;
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done_o);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    @(negedge clk);
    chk(!mem_read_o && !wr_en_o && !done_o && !busy_o, "R1 in reset", {28'd0, mem_read_o, wr_en_o, done_o, busy_o}, 0);
    @(posedge clk); #2;
    rst = 1'b0;
    @(negedge clk);
    chk(!mem_read_o && !wr_en_o && !done_o && !busy_o, "R1 after reset", {28'd0, mem_read_o, wr_en_o, done_o, busy_o}, 0);
    compare_on = 1;

    // zero-wait fill
    wait_mode = 0;
    drive_start(23'h000010);
    wait_done();

    // random stalls, with starts pulsed mid-fill (R9)
    wait_mode = 1;
    drive_start(23'h1234A8);
    repeat (20) @(posedge clk);
    drive_start(23'h0ABCD0);
    repeat (37) @(posedge clk);
    drive_start(23'h3FFF00);
    wait_done();
    repeat (3) @(posedge clk);

    // top of address space with heavy stalls (R10)
    wait_mode = 2;
    drive_start(23'h7FFFF0);
    repeat (60) @(posedge clk);
    drive_start(23'h000000);
    wait_done();

    // start held high: restart taken in the done cycle
    wait_mode = 1;
    @(posedge clk); #2;
    line_addr_i = 23'h055550;
    start_i = 1'b1;
    wait_done();
    @(posedge clk); #2;
    line_addr_i = 23'h02AAA0;
    wait_done();
    @(posedge clk); #2;
    start_i = 1'b0;
    wait_done();
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(!busy_o && !mem_read_o, "R8 idle at end", {30'd0, busy_o, mem_read_o}, 0);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end
endmodule